// File: doc/BRIEF.md
# Flash Program/Erase Status Byte Generator

This block forms the byte a host sees when it reads a flash device while an embedded program or erase is running, has failed, or has been suspended. The operation sequencer reports its state on a 3-bit mode input. The address decoder supplies the block index of the current read. Two masks mark the blocks selected for erase and the blocks that failed to erase. The block returns an 8-bit status byte and a select line that tells the read-data multiplexer whether to drive that byte or the array word.

Two of the status bits are toggle flops that advance once per completed read, signalled by a one-cycle `rd_done` pulse. Host software can then tell a running controller, whose bits keep moving, from a stopped one, whose bits hold. One toggle bit advances on every read. The other advances only for reads inside erasing blocks, or, after an erase failure, only inside failed blocks, so software can locate the bad blocks. The status byte is combinational from the mode, the address and the two toggle flops. A toggle change caused by a read therefore shows on the following read.

Top module: `flash_status_gen`

## Requirements
- R1: After a synchronous active-low reset, both toggle flops are 0. In idle mode (`op_mode` 0) the status byte then reads 00h and `status_sel` is 0.
- R2: `op_mode` codes are: 0 idle, 1 program, 2 erase selection window, 3 erase running, 4 erase suspended, 5 program failed, 6 erase failed, 7 treated as idle. `status_sel` is 1 in modes 1, 2, 3, 5 and 6. It is 0 in modes 0 and 7. In mode 4 it is 1 only when `rd_blk` addresses a block set in `erase_mask`.
- R3: Bit 7 is the inverse of `prog_d7` in modes 1 and 5. It is 1 in mode 4 and 0 in every other mode.
- R4: Bit 6 is a toggle flop. It inverts on each `rd_done` pulse in modes 1, 2, 3, 5 and 6, and holds in modes 0, 4 and 7.
- R5: Bit 5 is 1 exactly in modes 5 and 6. It stays 1 for as long as the sequencer holds a failed mode.
- R6: Bit 3 is 0 in mode 2 and in all modes other than 3, 4 and 6. It is 1 in modes 3, 4 and 6.
- R7: Bit 2 is a toggle flop. In modes 2, 3 and 4 it inverts on `rd_done` only when `rd_blk` addresses a block set in `erase_mask`. In modes 0, 1, 5 and 7 it holds.
- R8: In mode 6, bit 2 inverts on `rd_done` only when `rd_blk` addresses a block set in `fail_mask`. It holds on reads of any other block.
- R9: Bits 4, 1 and 0 always read 0.
- R10: A `rd_blk` value equal to or above `NUM_BLKS` lies outside both masks. Such a read returns array data in mode 4 and never advances bit 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_mode | input | 3 | Operation state from the sequencer (codes in R2) |
| rd_done | input | 1 | One-cycle pulse marking the completion of a bus read |
| rd_blk | input | IDX_W | Block index of the read address |
| erase_mask | input | NUM_BLKS | Blocks selected for erase |
| fail_mask | input | NUM_BLKS | Blocks that failed to erase |
| prog_d7 | input | 1 | Bit 7 of the datum being programmed |
| status | output | 8 | Status byte |
| status_sel | output | 1 | 1 selects the status byte, 0 selects array data |

## Verification
The assertions take for granted that `op_mode`, `rd_blk`, both masks and `prog_d7` hold steady around the clock edge where `rd_done` is sampled. They also take `rd_done` to be a single-cycle pulse per read, so each toggle advances at most once per read. The stimulus changes every input only on the falling edge and raises `rd_done` for exactly one rising edge per step. It draws modes over all eight codes, including the reserved one, and block indices up to 15, so out-of-range indices occur regularly. Directed runs place reads in suspended and erase-failed states against good and failed blocks.

// File: rtl/sreg_pkg.sv
// Shared types for the flash status byte generator.
// Assumes the sequencer encodes its state in three bits as listed below.
package sreg_pkg;

    typedef enum logic [2:0] {
        OPM_IDLE      = 3'd0,
        OPM_PROG      = 3'd1,
        OPM_ERS_WIN   = 3'd2,
        OPM_ERS_RUN   = 3'd3,
        OPM_SUSP      = 3'd4,
        OPM_PROG_FAIL = 3'd5,
        OPM_ERS_FAIL  = 3'd6,
        OPM_RSVD      = 3'd7
    } opm_e;

    typedef enum logic [1:0] {
        POLL_ZERO = 2'd0,
        POLL_INV  = 2'd1,
        POLL_ONE  = 2'd2
    } poll_e;

    typedef struct packed {
        logic  sel_all;     // every read returns status
        logic  sel_erasing; // only reads in erasing blocks return status
        logic  tog6_en;     // read toggle bit advances
        logic  tog2_ers;    // erase toggle advances inside erasing blocks
        logic  tog2_fail;   // erase toggle advances inside failed blocks
        logic  err;         // failure flag
        logic  started;     // erase has left its selection window
        poll_e poll;        // polling bit source
    } sreg_ctl_t;

    localparam int unsigned BIT_POLL  = 7;
    localparam int unsigned BIT_TOG   = 6;
    localparam int unsigned BIT_ERR   = 5;
    localparam int unsigned BIT_START = 3;
    localparam int unsigned BIT_ATOG  = 2;

endpackage

// File: rtl/sreg_mode_decode.sv
// Decodes the sequencer mode into per-bit controls for the status byte.
// Assumes the mode is stable for the cycle it is decoded in; code 7 acts as idle.
module sreg_mode_decode
    import sreg_pkg::*;
(
    input  opm_e      mode,
    output sreg_ctl_t ctl
);

    // Map each mode to its select, toggle and fixed-bit behaviour.
    always_comb begin
        ctl = '{sel_all: 1'b0, sel_erasing: 1'b0, tog6_en: 1'b0,
                tog2_ers: 1'b0, tog2_fail: 1'b0, err: 1'b0,
                started: 1'b0, poll: POLL_ZERO};
        case (mode)
            OPM_PROG: begin
                ctl.sel_all = 1'b1;
                ctl.tog6_en = 1'b1;
                ctl.poll    = POLL_INV;
            end
            OPM_ERS_WIN: begin
                ctl.sel_all  = 1'b1;
                ctl.tog6_en  = 1'b1;
                ctl.tog2_ers = 1'b1;
            end
            OPM_ERS_RUN: begin
                ctl.sel_all  = 1'b1;
                ctl.tog6_en  = 1'b1;
                ctl.tog2_ers = 1'b1;
                ctl.started  = 1'b1;
            end
            OPM_SUSP: begin
                ctl.sel_erasing = 1'b1;
                ctl.tog2_ers    = 1'b1;
                ctl.started     = 1'b1;
                ctl.poll        = POLL_ONE;
            end
            OPM_PROG_FAIL: begin
                ctl.sel_all = 1'b1;
                ctl.tog6_en = 1'b1;
                ctl.err     = 1'b1;
                ctl.poll    = POLL_INV;
            end
            OPM_ERS_FAIL: begin
                ctl.sel_all   = 1'b1;
                ctl.tog6_en   = 1'b1;
                ctl.tog2_fail = 1'b1;
                ctl.err       = 1'b1;
                ctl.started   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sreg_blk_lookup.sv
// Tells whether a block index falls on a set bit of a block mask.
// Assumes indices at or above NUM_BLKS address no block and so never hit.
module sreg_blk_lookup #(
    parameter int unsigned NUM_BLKS = 11,
    parameter int unsigned IDX_W    = 4
) (
    input  logic [IDX_W-1:0]    idx,
    input  logic [NUM_BLKS-1:0] mask,
    output logic                hit
);

    logic [NUM_BLKS-1:0] match;

    // One comparator per block; at most one can match.
    for (genvar g = 0; g < NUM_BLKS; g++) begin : g_blk
        assign match[g] = (idx == IDX_W'(g)) && mask[g];
    end

    assign hit = |match;

endmodule

// File: rtl/sreg_toggle_bit.sv
// One status toggle bit: inverts on a completed read when enabled.
// Assumes the strobe is a one-cycle pulse per read; reset is synchronous, active low.
module sreg_toggle_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic en,
    output logic q
);

    // Advance on each enabled read completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (strobe && en)
            q <= ~q;
    end

    // R4 / R7: an enabled read flips the bit.
    a_r4_r7_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && en) |=> (q != $past(q)));

    // R4 / R7: without an enabled read the bit holds.
    a_r4_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe && en) |=> $stable(q));

endmodule

// File: rtl/flash_status_gen.sv
// Builds the status byte returned on reads during program/erase activity
// and the select that chooses it over array data.
// Assumes mode, block index and masks are steady while rd_done is sampled.
module flash_status_gen
    import sreg_pkg::*;
#(
    parameter int unsigned NUM_BLKS = 11,
    parameter int unsigned IDX_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          op_mode,
    input  logic                rd_done,
    input  logic [IDX_W-1:0]    rd_blk,
    input  logic [NUM_BLKS-1:0] erase_mask,
    input  logic [NUM_BLKS-1:0] fail_mask,
    input  logic                prog_d7,
    output logic [7:0]          status,
    output logic                status_sel
);

    localparam int unsigned IDX_SPAN = 1 << IDX_W;

    opm_e      mode;
    sreg_ctl_t ctl;
    logic      ers_hit;
    logic      fail_hit;
    logic      tog6_q;
    logic      tog2_q;
    logic      tog2_en;
    logic      poll_bit;

    assign mode = opm_e'(op_mode);

    sreg_mode_decode u_dec (
        .mode (mode),
        .ctl  (ctl)
    );

    sreg_blk_lookup #(.NUM_BLKS(NUM_BLKS), .IDX_W(IDX_W)) u_ers_lu (
        .idx  (rd_blk),
        .mask (erase_mask),
        .hit  (ers_hit)
    );

    sreg_blk_lookup #(.NUM_BLKS(NUM_BLKS), .IDX_W(IDX_W)) u_fail_lu (
        .idx  (rd_blk),
        .mask (fail_mask),
        .hit  (fail_hit)
    );

    // Erase toggle advances in erasing blocks, or failed blocks after an erase error.
    assign tog2_en = (ctl.tog2_ers && ers_hit) || (ctl.tog2_fail && fail_hit);

    sreg_toggle_bit u_tog6 (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (rd_done),
        .en     (ctl.tog6_en),
        .q      (tog6_q)
    );

    sreg_toggle_bit u_tog2 (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (rd_done),
        .en     (tog2_en),
        .q      (tog2_q)
    );

    // Select the polling bit source.
    always_comb begin
        case (ctl.poll)
            POLL_INV: poll_bit = ~prog_d7;
            POLL_ONE: poll_bit = 1'b1;
            default:  poll_bit = 1'b0;
        endcase
    end

    // Assemble the status byte; unused positions read 0.
    always_comb begin
        status            = 8'h00;
        status[BIT_POLL]  = poll_bit;
        status[BIT_TOG]   = tog6_q;
        status[BIT_ERR]   = ctl.err;
        status[BIT_START] = ctl.started;
        status[BIT_ATOG]  = tog2_q;
    end

    // Status over array data: always when busy, only in erasing blocks when suspended.
    assign status_sel = ctl.sel_all || (ctl.sel_erasing && ers_hit);

    initial begin
        a_r10_idx_span: assert (IDX_SPAN >= NUM_BLKS);
    end

    // R2: idle and reserved modes pass array data through.
    a_r2_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 3'd0 || op_mode == 3'd7) |-> !status_sel);

    // R3: program polling returns the complemented datum bit.
    a_r3_prog_poll: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 3'd1) |-> (status[7] == ~prog_d7));

    // R5: failed modes report the error bit.
    a_r5_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 3'd5 || op_mode == 3'd6) |-> status[5]);

    // R6: selection window reads bit 3 as 0.
    a_r6_window_low: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 3'd2) |-> !status[3]);

    // R8: after an erase error, reads of good blocks leave bit 2 alone.
    a_r8_good_blk_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 3'd6 && !fail_hit) |=> $stable(tog2_q));

    // R10: an out-of-range index never hits a mask.
    a_r10_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_blk >= IDX_W'(NUM_BLKS)) |-> (!ers_hit && !fail_hit));

endmodule

// File: tb/flash_status_gen_bench.sv
`timescale 1ns/1ps
module flash_status_gen_bench;

    localparam int NB = 11;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    op_mode = 3'd0;
    logic          rd_done = 1'b0;
    logic [IW-1:0] rd_blk = '0;
    logic [NB-1:0] erase_mask = '0;
    logic [NB-1:0] fail_mask = '0;
    logic          prog_d7 = 1'b0;
    logic [7:0]    status;
    logic          status_sel;

    int checks = 0;
    int failures = 0;
    logic m6 = 1'b0;
    logic m2 = 1'b0;

    always #2.5 clk = ~clk;

    flash_status_gen #(.NUM_BLKS(NB), .IDX_W(IW)) u_flash_status_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_mode    (op_mode),
        .rd_done    (rd_done),
        .rd_blk     (rd_blk),
        .erase_mask (erase_mask),
        .fail_mask  (fail_mask),
        .prog_d7    (prog_d7),
        .status     (status),
        .status_sel (status_sel)
    );

    function automatic logic hit(input logic [NB-1:0] m, input int b);
        return (b < NB) ? m[b] : 1'b0;
    endfunction

    function automatic logic [7:0] exp_status(input int m, input logic t6,
                                              input logic t2, input logic pd);
        logic [7:0] s = 8'h00;
        s[7] = (m == 1 || m == 5) ? ~pd : (m == 4);
        s[6] = t6;
        s[5] = (m == 5 || m == 6);
        s[3] = (m == 3 || m == 4 || m == 6);
        s[2] = t2;
        return s;
    endfunction

    function automatic logic exp_sel(input int m, input logic ehit);
        if (m == 1 || m == 2 || m == 3 || m == 5 || m == 6) return 1'b1;
        if (m == 4) return ehit;
        return 1'b0;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // One read step: drive on falling edge, check before rising edge, update model.
    task automatic step(input int m, input int b, input logic [NB-1:0] em,
                        input logic [NB-1:0] fm, input logic pd, input logic st);
        logic [7:0] e;
        logic       ehit;
        logic       fhit;
        @(negedge clk);
        op_mode = 3'(m); rd_blk = IW'(b); erase_mask = em;
        fail_mask = fm; prog_d7 = pd; rd_done = st;
        #1;
        ehit = hit(em, b);
        fhit = hit(fm, b);
        e = exp_status(m, m6, m2, pd);
        chk("R3 bit7", {7'd0, status[7]}, {7'd0, e[7]});
        chk("R4 bit6", {7'd0, status[6]}, {7'd0, e[6]});
        chk("R5 bit5", {7'd0, status[5]}, {7'd0, e[5]});
        chk("R6 bit3", {7'd0, status[3]}, {7'd0, e[3]});
        chk((m == 6) ? "R8 bit2" : "R7 bit2", {7'd0, status[2]}, {7'd0, e[2]});
        chk("R9 bits4_1_0", status & 8'h13, 8'h00);
        chk((b >= NB) ? "R10 sel" : "R2 sel", {7'd0, status_sel}, {7'd0, exp_sel(m, ehit)});
        @(posedge clk);
        if (st) begin
            if (m == 1 || m == 2 || m == 3 || m == 5 || m == 6) m6 = ~m6;
            if (((m == 2 || m == 3 || m == 4) && ehit) || (m == 6 && fhit)) m2 = ~m2;
        end
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state in idle
        chk("R1 status", status, 8'h00);
        chk("R1 sel", {7'd0, status_sel}, 8'h00);

        // Directed: running erase toggles, then suspend freezes bit 6 (R4), R7 in erasing block
        step(3, 2, 11'h004, 11'h000, 1'b0, 1'b1);
        step(3, 5, 11'h004, 11'h000, 1'b0, 1'b1);
        step(4, 2, 11'h004, 11'h000, 1'b0, 1'b1);
        step(4, 2, 11'h004, 11'h000, 1'b0, 1'b1);
        step(4, 7, 11'h004, 11'h000, 1'b0, 1'b1);
        // Directed: erase failure, good vs failed blocks (R8)
        step(6, 1, 11'h006, 11'h004, 1'b0, 1'b1);
        step(6, 1, 11'h006, 11'h004, 1'b0, 1'b1);
        step(6, 2, 11'h006, 11'h004, 1'b0, 1'b1);
        step(6, 2, 11'h006, 11'h004, 1'b0, 1'b0);
        // Directed: out-of-range index (R10) with all masks set
        step(4, 11, 11'h7ff, 11'h7ff, 1'b1, 1'b1);
        step(6, 15, 11'h7ff, 11'h7ff, 1'b1, 1'b1);
        step(2, 10, 11'h7ff, 11'h000, 1'b1, 1'b1);
        // Directed: program polling both datum values (R3)
        step(1, 0, 11'h000, 11'h000, 1'b1, 1'b1);
        step(5, 0, 11'h000, 11'h000, 1'b0, 1'b0);

        // Random mix over every mode code
        for (int i = 0; i < 3000; i++) begin
            step(int'($urandom_range(0, 7)), int'($urandom_range(0, 15)),
                 NB'($urandom), NB'($urandom), 1'($urandom), 1'($urandom));
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule